// File: doc/BRIEF.md
# Reloadable Interval Timer Channel

This block is one channel of a memory-mapped interval timer. It has a 32-bit counter that counts down, a 32-bit reload register and a small control register. A byte-wide start register is shared between up to eight channels. This channel owns one bit of that register and counts only while its bit is set. The count clock is the peripheral clock divided by a prescaler, with five ratios selected in the control register. When the counter is zero on a count tick, it reloads from the reload register and sets an underflow flag. If the interrupt is enabled, the flag drives a level interrupt request.

Software stops the channel and loads the counter and the reload register directly. Loading different values gives a first interval that differs from the repeating one. Software then sets its run bit. Writing the control register both sets the interrupt enable and acknowledges a pending underflow. With a reload value of all ones the channel is a free-running timebase, and XOR with all ones turns the counter into an up-counting value. The bus has a write port and a separate read port. Reads are combinational, so the counter can be sampled at any time.

Top module: `ivt_channel`

## Requirements
- R1: After reset, the counter and the reload register both read 0xFFFFFFFF. The start register and the control register read 0, and `irq` is low.
- R2: Register addresses are: start = 0, reload = 1, counter = 2, control = 3. The counter holds its value while the channel's run bit (bit CH_IDX of the start register, default bit 0) is 0. The other start bits are stored and read back but do not affect the channel.
- R3: Control code 000 in bits 2:0 divides by 4. After the edge that sets the run bit, the counter first decrements on the 4th clock edge and then once every 4 edges.
- R4: Control bits 2:0 select the other ratios: 001 gives /16, 010 gives /64, 011 gives /256 and 100 gives /1024. Codes 101 to 111 also give /1024. The first decrement comes that many edges after the run edge.
- R5: On a count tick with the counter at 0, the counter loads the reload value and the underflow flag (control bit 8) becomes 1.
- R6: `irq` is a level output equal to underflow flag AND interrupt enable (control bit 5). With bit 5 at 0, the flag still sets but `irq` stays low.
- R7: A control write with bit 8 = 0 clears the flag. A write with bit 8 = 1 leaves it unchanged. If an underflow falls on the same edge as a clearing write, the flag stays set.
- R8: The counter and the reload register can be written at any time. If a counter write and a count tick fall on the same edge, the write wins and that tick is lost (no decrement, no underflow).
- R9: The prescaler is held at zero while the run bit is 0. After a stop and restart, the first decrement comes a full division period after the restart edge.
- R10: With reload 0xFFFFFFFF the channel runs freely. After an underflow the counter reads 0xFFFFFFFF, and counter XOR 0xFFFFFFFF counts up by one per tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for writes |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Register select for reads |
| rd_data | output | CNT_W | Combinational read data |
| irq | output | 1 | Level interrupt request |

## Verification
Every write commits on one clock edge, and the result reads back combinationally after that edge. Register, flag and `irq` results are therefore due in the cycle numbered by the write edge. A count result is due exactly N×(value+1) edges after the run edge for divide ratio N. An underflow lands on the tick that finds the counter at 0. The bench numbers the edges and computes the due edge of each expected item from these rules. Its monitor samples at the falling edge of exactly that cycle, so a result one cycle early or late is reported. Collisions are placed on purpose: a clearing write on an underflow edge, and a counter write on a tick edge.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    // register addresses on the bus
    typedef enum logic [1:0] {
        ADR_START  = 2'd0,
        ADR_RELOAD = 2'd1,
        ADR_COUNT  = 2'd2,
        ADR_CTRL   = 2'd3
    } reg_addr_e;

    // control field positions
    localparam int PSEL_W = 3;
    localparam int IE_BIT = 5;
    localparam int UF_BIT = 8;

    // prescaler geometry: ratio 4^(sel+1), largest select index MAX_SEL
    localparam int DIV_STEP = 2;
    localparam int MAX_SEL  = 4;
    localparam int PRE_W    = DIV_STEP * (MAX_SEL + 1);

    typedef struct packed {
        logic              ie;
        logic [PSEL_W-1:0] psel;
    } ctrl_t;

    // mask of prescaler bits that must all be one for a count tick
    function automatic logic [PRE_W-1:0] tick_mask(input logic [PSEL_W-1:0] psel);
        int sel;
        logic [PRE_W-1:0] m;
        sel = (int'(psel) > MAX_SEL) ? MAX_SEL : int'(psel);
        m = '0;
        for (int i = 0; i < PRE_W; i++) begin
            if (i < DIV_STEP * (sel + 1)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler
    import ivt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [PSEL_W-1:0] psel,
    output logic              tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    always_comb mask = tick_mask(psel);

    assign tick = run && ((pre_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !run) pre_q <= '0;
        else             pre_q <= pre_q + PRE_W'(1);
    end
endmodule

// File: rtl/ivt_count_core.sv
module ivt_count_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             cnt_we,
    input  logic             rld_we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] rld_q,
    output logic             uf_pulse
);
    logic at_zero;

    assign at_zero  = (cnt_q == '0);
    assign uf_pulse = tick && at_zero && !cnt_we;

    always_ff @(posedge clk) begin
        if (rst)            cnt_q <= '1;
        else if (cnt_we)    cnt_q <= wdata;
        else if (tick)      cnt_q <= at_zero ? rld_q : cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)         rld_q <= '1;
        else if (rld_we) rld_q <= wdata;
    end
endmodule

// File: rtl/ivt_ctrl_reg.sv
module ivt_ctrl_reg
    import ivt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  ctrl_t wfields,
    input  logic  wflag,
    input  logic  uf_pulse,
    output ctrl_t ctrl_q,
    output logic  uf_flag
);
    always_ff @(posedge clk) begin
        if (rst)     ctrl_q <= '0;
        else if (we) ctrl_q <= wfields;
    end

    // an underflow on the same edge outranks an acknowledge
    always_ff @(posedge clk) begin
        if (rst)                 uf_flag <= 1'b0;
        else if (uf_pulse)       uf_flag <= 1'b1;
        else if (we && !wflag)   uf_flag <= 1'b0;
    end
endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
    import ivt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int RUN_W  = 8,
    parameter int CH_IDX = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq
);
    localparam int CW = (CNT_W > UF_BIT) ? CNT_W : UF_BIT + 1;

    reg_addr_e        waddr;
    reg_addr_e        raddr;
    logic [RUN_W-1:0] start_q;
    logic             run;
    logic             tick;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] rld_q;
    logic             uf_pulse;
    logic             uf_flag;
    ctrl_t            ctrl_q;
    ctrl_t            wfields;
    logic [CW-1:0]    wide_wr;
    logic [CW-1:0]    ctrl_word;
    logic             irq_en;

    assign waddr   = reg_addr_e'(wr_addr);
    assign raddr   = reg_addr_e'(rd_addr);
    assign wide_wr = CW'(wr_data);

    // shared run register: one bit per channel
    always_ff @(posedge clk) begin
        if (rst)                              start_q <= '0;
        else if (wr_en && waddr == ADR_START) start_q <= wr_data[RUN_W-1:0];
    end
    assign run = start_q[CH_IDX];

    ivt_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .psel (ctrl_q.psel),
        .tick (tick)
    );

    ivt_count_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .cnt_we   (wr_en && waddr == ADR_COUNT),
        .rld_we   (wr_en && waddr == ADR_RELOAD),
        .wdata    (wr_data),
        .cnt_q    (cnt_q),
        .rld_q    (rld_q),
        .uf_pulse (uf_pulse)
    );

    always_comb begin
        wfields.ie   = wide_wr[IE_BIT];
        wfields.psel = wide_wr[PSEL_W-1:0];
    end

    ivt_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .we       (wr_en && waddr == ADR_CTRL),
        .wfields  (wfields),
        .wflag    (wide_wr[UF_BIT]),
        .uf_pulse (uf_pulse),
        .ctrl_q   (ctrl_q),
        .uf_flag  (uf_flag)
    );

    assign irq_en = ctrl_q.ie;
    assign irq    = uf_flag && irq_en;

    always_comb begin
        ctrl_word                = '0;
        ctrl_word[UF_BIT]        = uf_flag;
        ctrl_word[IE_BIT]        = ctrl_q.ie;
        ctrl_word[PSEL_W-1:0]    = ctrl_q.psel;
    end

    always_comb begin
        unique case (raddr)
            ADR_START:  rd_data = CNT_W'(start_q);
            ADR_RELOAD: rd_data = rld_q;
            ADR_COUNT:  rd_data = cnt_q;
            default:    rd_data = ctrl_word[CNT_W-1:0];
        endcase
    end
endmodule

// File: rtl/ivt_channel_chk.sv
module ivt_channel_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [CNT_W-1:0] wr_data,
    input logic             irq,
    input logic             run,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] reload,
    input logic             flag,
    input logic             ie
);
    logic cnt_wr;
    assign cnt_wr = wr_en && (wr_addr == 2'd2);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (cnt == '1 && reload == '1 && !flag && !run && !irq)); // R1

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr) |=> $stable(cnt)); // R2

    AST_DECREMENT_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt != '0 && !cnt_wr) |=> (cnt == $past(cnt) - CNT_W'(1))); // R3

    AST_UNDERFLOW_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt == '0 && !cnt_wr) |=> (cnt == $past(reload) && flag)); // R5

    AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(tick && cnt == '0)); // R5

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        !ie |-> !irq); // R6

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (cnt == $past(wr_data))); // R8

    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        tick |-> run); // R9
endmodule

bind ivt_channel ivt_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .irq     (irq),
    .run     (run),
    .tick    (tick),
    .cnt     (cnt_q),
    .reload  (rld_q),
    .flag    (uf_flag),
    .ie      (irq_en)
);

// File: tb/ivt_channel_test.sv
`timescale 1ns/100ps
module ivt_channel_test;
    localparam int A_START = 0, A_RELOAD = 1, A_COUNT = 2, A_CTRL = 3;
    localparam int K_IRQ = 4, K_UPVIEW = 5;

    typedef struct {
        int          due;
        int          kind;
        logic [31:0] val;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   ended = 0;
    exp_t sb[$];

    ivt_channel uut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .irq     (irq)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(int due, int kind, logic [31:0] v, string tag);
        exp_t e;
        e.due = due; e.kind = kind; e.val = v; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic write_at(int edge_no, int a, logic [31:0] d);
        if (cyc > edge_no - 1) begin
            errors++;
            $display("FAIL sched: write edge %0d already past (now %0d)", edge_no, cyc);
        end
        while (cyc < edge_no - 1) @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // monitor: pop items that are due this cycle and compare
    always @(negedge clk) begin
        logic [31:0] got;
        if (!rst) begin
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].due < cyc) begin
                    checks++; errors++;
                    $display("FAIL %s: item kind %0d due %0d missed", sb[i].tag, sb[i].kind, sb[i].due);
                    sb.delete(i);
                end else if (sb[i].due == cyc) begin
                    if (sb[i].kind == K_IRQ) begin
                        got = {31'd0, irq};
                    end else begin
                        rd_addr = (sb[i].kind == K_UPVIEW) ? 2'(A_COUNT) : 2'(sb[i].kind);
                        #0.2;
                        got = (sb[i].kind == K_UPVIEW) ? (rd_data ^ 32'hFFFF_FFFF) : rd_data;
                    end
                    checks++;
                    if (got !== sb[i].val) begin
                        errors++;
                        $display("FAIL %s: kind %0d cycle %0d actual %h expected %h",
                                 sb[i].tag, sb[i].kind, cyc, got, sb[i].val);
                    end
                    sb.delete(i);
                end
            end
        end
    end

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end

    initial begin
        int t, k, s, b, c, d, e, f, g, h;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t = cyc;

        // R1 reset values
        expect_at(t + 1, A_COUNT,  32'hFFFF_FFFF, "R1");
        expect_at(t + 1, A_RELOAD, 32'hFFFF_FFFF, "R1");
        expect_at(t + 1, A_CTRL,   32'h0, "R1");
        expect_at(t + 1, A_START,  32'h0, "R1");
        expect_at(t + 1, K_IRQ,    32'h0, "R1");

        // R2 stopped channel holds; foreign run bits ignored
        write_at(t + 3, A_COUNT, 32'd10);
        write_at(t + 4, A_START, 32'hFE);
        expect_at(t + 5,  A_START, 32'hFE, "R2");
        expect_at(t + 24, A_COUNT, 32'd10, "R2");

        // R3 /4 counting, R5 underflow, R6 interrupt
        write_at(t + 26, A_CTRL, 32'h20);
        write_at(t + 27, A_RELOAD, 32'd20);
        k = t + 30;
        write_at(k, A_START, 32'h01);
        expect_at(k + 3,  A_COUNT, 32'd10, "R3");
        expect_at(k + 4,  A_COUNT, 32'd9,  "R3");
        expect_at(k + 8,  A_COUNT, 32'd8,  "R3");
        expect_at(k + 43, A_COUNT, 32'd0,  "R5");
        expect_at(k + 43, K_IRQ,   32'd0,  "R6");
        expect_at(k + 44, A_COUNT, 32'd20, "R5");
        expect_at(k + 44, A_CTRL,  32'h120, "R5");
        expect_at(k + 44, K_IRQ,   32'd1,  "R6");

        // R7 acknowledge rules
        expect_at(k + 60, A_CTRL, 32'h120, "R7");
        expect_at(k + 60, K_IRQ,  32'd1,   "R7");
        write_at(k + 60, A_CTRL, 32'h120);
        expect_at(k + 70, A_CTRL, 32'h020, "R7");
        expect_at(k + 70, K_IRQ,  32'd0,   "R7");
        write_at(k + 70, A_CTRL, 32'h020);

        // R6 masked interrupt while flag sets
        write_at(k + 100, A_CTRL, 32'h000);
        expect_at(k + 128, A_CTRL,  32'h100, "R6");
        expect_at(k + 128, K_IRQ,   32'd0,   "R6");
        expect_at(k + 128, A_COUNT, 32'd20,  "R5");
        expect_at(k + 140, A_CTRL,  32'h020, "R7");
        write_at(k + 140, A_CTRL, 32'h020);

        // R7 clear collides with underflow: flag stays
        expect_at(k + 212, A_CTRL, 32'h120, "R7");
        expect_at(k + 212, K_IRQ,  32'd1,   "R7");
        write_at(k + 212, A_CTRL, 32'h020);

        // R8 counter write on a tick edge wins; reload writable while running
        expect_at(k + 216, A_COUNT, 32'd500, "R8");
        expect_at(k + 220, A_COUNT, 32'd499, "R8");
        write_at(k + 216, A_COUNT, 32'd500);
        expect_at(k + 218, A_RELOAD, 32'h77, "R8");
        write_at(k + 218, A_RELOAD, 32'h77);

        // R9 prescaler cleared while stopped
        write_at(k + 222, A_START, 32'h0);
        expect_at(k + 229, A_COUNT, 32'd499, "R9");
        s = k + 230;
        expect_at(s + 3, A_COUNT, 32'd499, "R9");
        expect_at(s + 4, A_COUNT, 32'd498, "R9");
        write_at(s, A_START, 32'h01);

        // R4 other division ratios
        write_at(s + 6, A_START, 32'h0);
        write_at(s + 8, A_COUNT, 32'd5);
        write_at(s + 9, A_CTRL, 32'h001);
        b = s + 12;
        expect_at(b + 15, A_COUNT, 32'd5, "R4");
        expect_at(b + 16, A_COUNT, 32'd4, "R4");
        write_at(b, A_START, 32'h01);
        write_at(b + 20, A_START, 32'h0);
        write_at(b + 21, A_CTRL, 32'h002);
        c = b + 24;
        expect_at(c + 63, A_COUNT, 32'd4, "R4");
        expect_at(c + 64, A_COUNT, 32'd3, "R4");
        write_at(c, A_START, 32'h01);
        write_at(c + 70, A_START, 32'h0);
        write_at(c + 71, A_CTRL, 32'h003);
        d = c + 74;
        expect_at(d + 255, A_COUNT, 32'd3, "R4");
        expect_at(d + 256, A_COUNT, 32'd2, "R4");
        write_at(d, A_START, 32'h01);
        write_at(d + 260, A_START, 32'h0);
        write_at(d + 261, A_CTRL, 32'h004);
        e = d + 264;
        expect_at(e + 1023, A_COUNT, 32'd2, "R4");
        expect_at(e + 1024, A_COUNT, 32'd1, "R4");
        write_at(e, A_START, 32'h01);
        write_at(e + 1030, A_START, 32'h0);
        write_at(e + 1031, A_CTRL, 32'h007);
        f = e + 1034;
        expect_at(f + 1023, A_COUNT, 32'd1, "R4");
        expect_at(f + 1024, A_COUNT, 32'd0, "R4");
        write_at(f, A_START, 32'h01);

        // R10 free-running timebase
        g = f + 1030;
        write_at(g, A_START, 32'h0);
        write_at(g + 1, A_RELOAD, 32'hFFFF_FFFF);
        write_at(g + 2, A_COUNT, 32'd0);
        write_at(g + 3, A_CTRL, 32'h000);
        h = g + 6;
        expect_at(h + 3,  A_COUNT,  32'd0,          "R10");
        expect_at(h + 4,  A_COUNT,  32'hFFFF_FFFF,  "R10");
        expect_at(h + 8,  K_UPVIEW, 32'd1,          "R10");
        expect_at(h + 12, K_UPVIEW, 32'd2,          "R10");
        write_at(h, A_START, 32'h01);

        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule